// File: doc/BRIEF.md
# Multi-Mode Serial Bit-Rate Tick Generator

This block produces the bit-rate tick for a serial port that can run in asynchronous or synchronous mode. An 8-bit divisor `n`, loaded through a write strobe, sets the period of a free-running reloadable timer. The timer is clocked at one quarter of the system clock. A second prescaler then divides the timer overflow by 16, by 4 or by 1. The mode select and the high-speed select together choose that final prescaler. The overall period is 64·(n+1) clocks in slow asynchronous mode, 16·(n+1) clocks in fast asynchronous mode and 4·(n+1) clocks in synchronous mode. In synchronous mode the high-speed select is ignored.

A write to the divisor restarts the whole chain at once: the quarter-rate stage, the timer and the prescaler all clear. The first tick at the new rate therefore comes exactly one full new period after the write, and the block never waits for an overflow that was pending. The raw timer overflow is also brought out as a one-cycle pulse. Shift registers, framing and receive sampling belong to the port that uses these ticks.

Top module: `baud_tick_gen`

## Requirements
- R1: A synchronous reset clears the divisor to 0 and holds `tick` and `ovf` low. With both mode inputs at 0 after reset, the first tick appears 64 clocks after the last reset edge.
- R2: With `sync_mode`=0 and `high_speed`=0, successive ticks are 64·(n+1) clocks apart.
- R3: With `sync_mode`=0 and `high_speed`=1, successive ticks are 16·(n+1) clocks apart.
- R4: With `sync_mode`=1, successive ticks are 4·(n+1) clocks apart, whatever the value of `high_speed`.
- R5: `ovf` is a one-clock pulse every 4·(n+1) clocks in every mode.
- R6: `tick` lasts exactly one clock and is only high in a cycle where `ovf` is high. In synchronous mode every `ovf` is accompanied by a `tick`.
- R7: A divisor write clears the chain, so `tick` and `ovf` are low in the cycle after the write. The first tick is high exactly one full new period (P·4·(n+1) clocks, where P is 16, 4 or 1) after the write edge.
- R8: n = 0 is legal and gives ticks every 64, 16 or 4 clocks.
- R9: A change of `sync_mode` or `high_speed` takes effect at the next timer overflow. If the prescaler count has already passed the new limit, the tick is issued at that overflow. Later ticks follow the new spacing.
- R10: With n = 25 in slow asynchronous mode the tick spacing is 1664 clocks. At a 16 MHz clock this is 9615 ticks per second, 0.16 % above 9600.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_wr | input | 1 | Divisor write strobe, restarts the chain |
| div_data | input | DIV_W (8) | New divisor value n |
| sync_mode | input | 1 | 1 = synchronous mode, 0 = asynchronous mode |
| high_speed | input | 1 | 1 = divide by 16·(n+1) in asynchronous mode; ignored in synchronous mode |
| tick | output | 1 | One-clock pulse at the final bit rate |
| ovf | output | 1 | One-clock pulse at each timer overflow |

## Verification
The assertions check the local relations on every cycle. Ticks never last longer than one clock and only occur with an overflow. Every overflow in synchronous mode produces a tick. A divisor write or a reset silences both outputs for the following cycle. Overflows are never adjacent. The exact tick and overflow spacings for each mode and divisor cannot be seen in a single cycle, and neither can the restart distance after a mid-period write or the settling after a mode change. Those are measured by the bench's scenarios, which count cycles between pulses.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W  = 8,
  parameter int QTR_W  = 2,
  parameter int PSC_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_data,
  input  logic             sync_mode,
  input  logic             high_speed,
  output logic             tick,
  output logic             ovf
);
  localparam logic [PSC_W-1:0] LIM_SLOW = PSC_W'(15);
  localparam logic [PSC_W-1:0] LIM_FAST = PSC_W'(3);
  localparam logic [PSC_W-1:0] LIM_SYNC = PSC_W'(0);

  logic [DIV_W-1:0] div_q, cnt;
  logic [QTR_W-1:0] qtr;
  logic [PSC_W-1:0] psc, lim;

  wire step = &qtr;
  wire roll = step && (cnt == '0);
  assign lim = sync_mode ? LIM_SYNC : (high_speed ? LIM_FAST : LIM_SLOW);
  wire wrap = roll && (psc >= lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt   <= '0;
      qtr   <= '0;
      psc   <= '0;
      tick  <= 1'b0;
      ovf   <= 1'b0;
    end else if (div_wr) begin
      div_q <= div_data;
      cnt   <= div_data;
      qtr   <= '0;
      psc   <= '0;
      tick  <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      qtr <= qtr + 1'b1;
      if (step) cnt <= (cnt == '0) ? div_q : cnt - 1'b1;
      if (roll) psc <= wrap ? '0 : psc + 1'b1;
      ovf  <= roll;
      tick <= wrap;
    end
  end
endmodule

module baud_tick_gen_chk (
  input logic clk,
  input logic rst,
  input logic div_wr,
  input logic sync_mode,
  input logic tick,
  input logic ovf
);
  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> (!tick && !ovf));
  assert_ovf_not_adjacent_R5: assert property (@(posedge clk) disable iff (rst) ovf |=> !ovf);
  assert_tick_single_R6: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
  assert_tick_with_ovf_R6: assert property (@(posedge clk) disable iff (rst) tick |-> ovf);
  assert_sync_every_ovf_R4: assert property (@(posedge clk) disable iff (rst)
    (ovf && $past(sync_mode) && !$past(rst)) |-> tick);
  assert_write_restart_R7: assert property (@(posedge clk) disable iff (rst) div_wr |=> (!tick && !ovf));
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
  .clk(clk), .rst(rst), .div_wr(div_wr), .sync_mode(sync_mode), .tick(tick), .ovf(ovf)
);

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic div_wr = 1'b0;
  logic [7:0] div_data = '0;
  logic sync_mode = 1'b0;
  logic high_speed = 1'b0;
  logic tick, ovf;
  int total = 0;
  int fails = 0;
  localparam int LIMIT = 70000;

  always #4 clk = ~clk;

  baud_tick_gen dut (
    .clk(clk), .rst(rst), .div_wr(div_wr), .div_data(div_data),
    .sync_mode(sync_mode), .high_speed(high_speed), .tick(tick), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output int c);
    c = 0;
    while (!tick && c < LIMIT) begin @(negedge clk); c++; end
  endtask

  task automatic next_tick(output int c);
    @(negedge clk); c = 1;
    while (!tick && c < LIMIT) begin @(negedge clk); c++; end
  endtask

  task automatic write_div(input int n);
    @(negedge clk); div_data = 8'(n); div_wr = 1'b1;
    @(negedge clk); div_wr = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tick && !ovf, "R1 outputs low in reset", {30'b0, tick, ovf}, 0);
    rst = 1'b0;
    begin
      int c;
      wait_tick(c);
      chk(c == 64, "R1 first tick after reset", c, 64);
    end
  endtask

  task automatic t_rate(input int n, input bit sm, input bit hs, input int p, input string req);
    int c;
    sync_mode = sm; high_speed = hs;
    write_div(n);
    chk(!tick && !ovf, "R7 quiet after write", {30'b0, tick, ovf}, 0);
    wait_tick(c);
    chk(c == p * 4 * (n + 1), {req, " first tick"}, c, p * 4 * (n + 1));
    next_tick(c);
    chk(c == p * 4 * (n + 1), {req, " spacing"}, c, p * 4 * (n + 1));
    @(negedge clk);
    chk(!tick, "R6 tick one cycle", int'(tick), 0);
  endtask

  task automatic t_ovf(input int n, input bit sm, input bit hs);
    int c;
    sync_mode = sm; high_speed = hs;
    write_div(n);
    c = 0;
    while (!ovf && c < LIMIT) begin @(negedge clk); c++; end
    chk(c == 4 * (n + 1), "R5 first ovf", c, 4 * (n + 1));
    @(negedge clk); c = 1;
    chk(!ovf, "R5 ovf one cycle", int'(ovf), 0);
    while (!ovf && c < LIMIT) begin @(negedge clk); c++; end
    chk(c == 4 * (n + 1), "R5 ovf spacing", c, 4 * (n + 1));
  endtask

  task automatic t_restart();
    int c;
    sync_mode = 1'b0; high_speed = 1'b0;
    write_div(200);
    c = 0;
    repeat (1000) begin @(negedge clk); if (tick) c++; end
    chk(c == 0, "R7 no tick mid old period", c, 0);
    write_div(3);
    wait_tick(c);
    chk(c == 256, "R7 restart after mid-period write", c, 256);
  endtask

  task automatic t_mode_change();
    int c;
    sync_mode = 1'b0; high_speed = 1'b0;
    write_div(1);
    repeat (100) @(negedge clk);
    sync_mode = 1'b1;
    wait_tick(c);
    chk(c <= 8, "R9 tick at next overflow after switch", c, 8);
    next_tick(c);
    chk(c == 8, "R9 new spacing after switch", c, 8);
    high_speed = 1'b1; sync_mode = 1'b0;
    wait_tick(c);
    next_tick(c);
    chk(c == 32, "R9 fast async spacing after switch", c, 32);
  endtask

  task automatic run_all();
    t_reset();
    t_rate(0, 1'b0, 1'b0, 16, "R8 n0 slow");
    t_rate(0, 1'b0, 1'b1, 4, "R8 n0 fast");
    t_rate(0, 1'b1, 1'b0, 1, "R8 n0 sync");
    t_rate(5, 1'b0, 1'b0, 16, "R2 n5");
    t_rate(25, 1'b0, 1'b0, 16, "R10 n25 9615 Hz");
    t_rate(7, 1'b0, 1'b1, 4, "R3 n7");
    t_rate(100, 1'b0, 1'b1, 4, "R3 n100");
    t_rate(9, 1'b1, 1'b0, 1, "R4 n9 hs0");
    t_rate(9, 1'b1, 1'b1, 1, "R4 n9 hs1 ignored");
    t_rate(255, 1'b1, 1'b1, 1, "R4 n255");
    t_ovf(6, 1'b0, 1'b0);
    t_ovf(2, 1'b1, 1'b0);
    t_restart();
    t_mode_change();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule